// File: doc/BRIEF.md
# Ultra DMA read-burst initiator

This block is the device end of a parallel ATA-style bus at the start of an Ultra DMA read burst. When its word source holds data, it raises the DMA request line. It then waits, with no time limit, for the host to acknowledge. After the acknowledge it waits out the envelope time. Next it waits for the host to drop its stop line and assert its ready line. Only then does it drive the 16-bit data bus and the data strobe. It sends the first word, makes the first strobe transition and then streams words, one per strobe edge. Data moves on both edges of the strobe.

Every interval is a whole number of system-clock cycles, taken from a per-mode timing set that is computed at elaboration from a clock-period parameter. A minimum time rounds up and a maximum time rounds down. The set covers data setup, data hold, first-strobe lead, envelope and the first-transition delays after drive-on. The transfer mode is a 3-bit input covering modes 0 to 5, and it is captured when a burst begins. Pausing, termination, CRC and the host side are not part of this block.

Top module: `udma_rd_init`

## Requirements
- R1: While reset is low at a clock edge, the block returns to rest: request low, bus and strobe not driven, strobe level 1, data register 0 and no source pop.
- R2: In the idle state, the request line rises on the first clock edge that sees the source valid. It then stays high for the rest of the burst.
- R3: Before the acknowledge (active low) is sampled low, the stop and ready lines have no effect: the bus stays undriven however they are set.
- R4: The bus drive enable rises exactly envelope-minimum + 1 edges after the edge that first samples the acknowledge low, when the host is already ready. That count is never below the envelope minimum and stays within the envelope maximum.
- R5: After the envelope wait, drive starts only on an edge that sees stop low and ready low (active low) together. The wait for this has no limit, and drive starts on the first edge where both hold.
- R6: On the drive-on edge, the first source word appears with the strobe at level 1. The first strobe transition is falling and comes lead edges later. Lead is the largest of the data-setup minimum, the data drive-to-first-transition minimum and the strobe drive-to-first-transition minimum, and it does not exceed the first-strobe maximum.
- R7: Each later word appears hold edges after the previous strobe transition. The strobe then changes setup edges after that word appears. The data never changes on an edge where the strobe changes.
- R8: Words leave in source order, with one source pop per word and one word per strobe transition. The strobe alternates level, so both edges carry data.
- R9: While the source is empty, the data and the strobe stay unchanged.
- R10: The mode is captured on the edge that leaves idle, so later changes to the mode input have no effect on that burst. Mode codes 6 and 7 use the mode-5 timing.
- R11: Each nanosecond limit becomes cycles of the clock-period parameter: minimums round up with a floor of 1 cycle, maximums round down. At 4 ns, setup is 18/12/8/5/2/2, hold is 2 in every mode, lead is 18/12/8/5/2/9, envelope minimum is 5, envelope maximum is 17/17/17/13/13/12 and the first-strobe maximum is 57/50/42/32/30/22 for modes 0 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 3 | Transfer mode code, captured at burst start |
| src_valid | input | 1 | Source holds at least one word |
| src_data | input | 16 | Word at the head of the source |
| src_pop | output | 1 | Head word taken this cycle |
| host_ack_n | input | 1 | Host DMA acknowledge, active low |
| host_stop | input | 1 | Host stop request, active high |
| host_ready_n | input | 1 | Host ready to receive, active low |
| dev_req | output | 1 | Device DMA request |
| dev_data_oe | output | 1 | Data bus and strobe driver enable |
| dev_data | output | 16 | Data bus value |
| dev_strobe | output | 1 | Device data strobe |

## Verification
A counter left holding a wrong value, or a mode captured wrongly, shows up as a shifted gap between edges. The gap from acknowledge to drive-on, from drive-on to the first strobe, or from a strobe edge to the next data change is off by one or more cycles, and this is visible within one word time of the fault. A sequencer that leaves a wait state too early drives the bus while the host is still stopped or not yet acknowledged, which shows on the drive enable on that same edge. A pop or load taken at the wrong time puts the wrong word, or an extra data change, on the bus before the next strobe edge.

// File: rtl/udma_rd_pkg.sv
// Package: shared widths, types and the ns-to-cycle conversion for the
// read-burst initiator. Assumes times are given in picoseconds.
package udma_rd_pkg;
    localparam int MODE_W   = 3;
    localparam int N_MODES  = 6;
    localparam int MAX_MODE = N_MODES - 1;
    localparam int DATA_W   = 16;
    localparam int CYC_W    = 8;
    localparam int ENV_MIN_PS = 20000;

    typedef struct packed {
        logic [CYC_W-1:0] setup;
        logic [CYC_W-1:0] hold;
        logic [CYC_W-1:0] lead;
        logic [CYC_W-1:0] fs_max;
        logic [CYC_W-1:0] env_min;
        logic [CYC_W-1:0] env_max;
    } udma_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQUEST, ST_WAIT_ACK, ST_WAIT_READY, ST_FIRST_STROBE, ST_STREAM
    } udma_state_t;

    typedef enum logic {PH_HOLD, PH_SETUP} udma_phase_t;

    // Minimum limit: round up, never below one cycle.
    function automatic int min_cyc(int ps, int clk_ps);
        int r;
        r = (ps + clk_ps - 1) / clk_ps;
        return (r < 1) ? 1 : r;
    endfunction

    // Maximum limit: round down.
    function automatic int max_cyc(int ps, int clk_ps);
        return ps / clk_ps;
    endfunction

    function automatic int setup_ps(int m);
        case (m)
            0: return 70000;
            1: return 48000;
            2: return 31000;
            3: return 20000;
            4: return 6700;
            default: return 4800;
        endcase
    endfunction

    function automatic int hold_ps(int m);
        return (m == 5) ? 4800 : 6200;
    endfunction

    function automatic int first_strobe_max_ps(int m);
        case (m)
            0: return 230000;
            1: return 200000;
            2: return 170000;
            3: return 130000;
            4: return 120000;
            default: return 90000;
        endcase
    endfunction

    function automatic int env_max_ps(int m);
        return (m <= 2) ? 70000 : ((m <= 4) ? 55000 : 50000);
    endfunction

    function automatic int data_on_ps(int m);
        case (m)
            0: return 70000;
            1: return 48000;
            2: return 31000;
            3: return 20000;
            4: return 6700;
            default: return 25000;
        endcase
    endfunction

    function automatic int strobe_on_ps(int m);
        return (m == 5) ? 35000 : 0;
    endfunction

    function automatic int max3(int a, int b, int c);
        int r;
        r = (a > b) ? a : b;
        return (r > c) ? r : c;
    endfunction
endpackage

// File: rtl/udma_rd_timing.sv
// Per-mode timing table in clock cycles, built at elaboration from CLK_PS.
// Assumes every converted value fits CYC_W bits. Codes above the last mode
// select the last mode.
module udma_rd_timing
    import udma_rd_pkg::*;
#(
    parameter int CLK_PS = 4000
) (
    input  logic [MODE_W-1:0] mode_q,
    output udma_timing_t      tim
);
    udma_timing_t table_w [N_MODES];
    logic [MODE_W-1:0] idx;

    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        localparam int SETUP_C = min_cyc(setup_ps(m), CLK_PS);
        localparam int HOLD_C  = min_cyc(hold_ps(m), CLK_PS);
        localparam int DON_C   = min_cyc(data_on_ps(m), CLK_PS);
        localparam int SON_C   = min_cyc(strobe_on_ps(m), CLK_PS);
        localparam int LEAD_C  = max3(SETUP_C, DON_C, SON_C);
        localparam int FSMAX_C = max_cyc(first_strobe_max_ps(m), CLK_PS);
        localparam int EMIN_C  = min_cyc(ENV_MIN_PS, CLK_PS);
        localparam int EMAX_C  = max_cyc(env_max_ps(m), CLK_PS);
        assign table_w[m] = '{setup:   CYC_W'(SETUP_C),
                              hold:    CYC_W'(HOLD_C),
                              lead:    CYC_W'(LEAD_C),
                              fs_max:  CYC_W'(FSMAX_C),
                              env_min: CYC_W'(EMIN_C),
                              env_max: CYC_W'(EMAX_C)};
    end

    // Clamp out-of-range codes onto the fastest mode.
    always_comb idx = (mode_q > MODE_W'(MAX_MODE)) ? MODE_W'(MAX_MODE) : mode_q;

    // Look up the captured mode.
    always_comb tim = table_w[idx];
endmodule

// File: rtl/udma_rd_fsm.sv
// Burst sequencer: request, acknowledge, envelope wait, host-ready wait,
// lead to first strobe, then the hold/setup stream. Emits one-cycle pulses
// to the word path. Assumes the source keeps a word at its head until popped.
module udma_rd_fsm
    import udma_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              src_valid,
    input  logic              host_ack_n,
    input  logic              host_stop,
    input  logic              host_ready_n,
    input  udma_timing_t      tim,
    output logic [MODE_W-1:0] mode_q,
    output logic              dev_req,
    output logic              drive_on,
    output logic              load_word,
    output logic              toggle
);
    udma_state_t       state;
    udma_phase_t       phase;
    logic [CYC_W-1:0]  cnt;
    logic              host_go;
    logic              cnt_done;

    // Host lets the burst proceed and a word is on hand.
    always_comb host_go = !host_stop && !host_ready_n && src_valid;
    always_comb cnt_done = (cnt == '0);

    // Pulses towards the word path.
    always_comb begin
        drive_on  = (state == ST_WAIT_READY) && host_go;
        load_word = drive_on ||
                    ((state == ST_STREAM) && (phase == PH_HOLD) && cnt_done && src_valid);
        toggle    = ((state == ST_FIRST_STROBE) && cnt_done) ||
                    ((state == ST_STREAM) && (phase == PH_SETUP) && cnt_done);
    end

    // State, interval counter and captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_HOLD;
            cnt     <= '0;
            dev_req <= 1'b0;
            mode_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (src_valid) begin
                        mode_q  <= mode_sel;
                        dev_req <= 1'b1;
                        state   <= ST_REQUEST;
                    end
                end
                ST_REQUEST: begin
                    if (!host_ack_n) begin
                        cnt   <= tim.env_min - 1'b1;
                        state <= ST_WAIT_ACK;
                    end
                end
                ST_WAIT_ACK: begin
                    if (cnt_done) state <= ST_WAIT_READY;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_WAIT_READY: begin
                    if (host_go) begin
                        cnt   <= tim.lead - 1'b1;
                        state <= ST_FIRST_STROBE;
                    end
                end
                ST_FIRST_STROBE: begin
                    if (cnt_done) begin
                        phase <= PH_HOLD;
                        cnt   <= tim.hold - 1'b1;
                        state <= ST_STREAM;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (!cnt_done) begin
                        cnt <= cnt - 1'b1;
                    end else if (phase == PH_HOLD) begin
                        if (src_valid) begin
                            phase <= PH_SETUP;
                            cnt   <= tim.setup - 1'b1;
                        end
                    end else begin
                        phase <= PH_HOLD;
                        cnt   <= tim.hold - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6 R4: the selected mode's table must leave room between its limits.
    assert_mode_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ((tim.lead <= tim.fs_max) && (tim.env_min <= tim.env_max)));

    // R2: leaving idle raises the request on that edge.
    assert_req_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(state) == ST_IDLE) && $past(src_valid)) |-> dev_req);
endmodule

// File: rtl/udma_rd_wordpath.sv
// Output register for the data bus, the strobe level and the driver enable.
// Assumes the sequencer never loads and toggles on the same edge.
module udma_rd_wordpath
    import udma_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_on,
    input  logic              load_word,
    input  logic              toggle,
    input  logic [DATA_W-1:0] src_data,
    output logic              dev_data_oe,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_strobe
);
    // Drive enable, data word and strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_data_oe <= 1'b0;
            dev_data    <= '0;
            dev_strobe  <= 1'b1;
        end else begin
            if (drive_on)  dev_data_oe <= 1'b1;
            if (load_word) dev_data    <= src_data;
            if (toggle)    dev_strobe  <= ~dev_strobe;
        end
    end

    // R7: data holds still on every edge that moves the strobe.
    assert_data_stable_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_data_oe && $past(dev_data_oe) && (dev_strobe != $past(dev_strobe)))
            |-> (dev_data == $past(dev_data)));

    // R1: one edge after reset the outputs are at rest.
    assert_rest_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!dev_data_oe && dev_strobe && (dev_data == '0)));
endmodule

// File: rtl/udma_rd_init.sv
// Top: device-side Ultra DMA read-burst initiator. Ties the sequencer, the
// timing table and the word path together. Assumes a clock period of CLK_PS
// picoseconds and host lines already synchronous to clk.
module udma_rd_init
    import udma_rd_pkg::*;
#(
    parameter int CLK_PS = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    input  logic              host_ack_n,
    input  logic              host_stop,
    input  logic              host_ready_n,
    output logic              dev_req,
    output logic              dev_data_oe,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_strobe
);
    udma_timing_t      tim;
    logic [MODE_W-1:0] mode_q;
    logic              drive_on;
    logic              load_word;
    logic              toggle;
    logic [CYC_W:0]    ack_age;

    udma_rd_timing #(.CLK_PS(CLK_PS)) u_timing (
        .mode_q (mode_q),
        .tim    (tim)
    );

    udma_rd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .src_valid    (src_valid),
        .host_ack_n   (host_ack_n),
        .host_stop    (host_stop),
        .host_ready_n (host_ready_n),
        .tim          (tim),
        .mode_q       (mode_q),
        .dev_req      (dev_req),
        .drive_on     (drive_on),
        .load_word    (load_word),
        .toggle       (toggle)
    );

    udma_rd_wordpath u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .drive_on    (drive_on),
        .load_word   (load_word),
        .toggle      (toggle),
        .src_data    (src_data),
        .dev_data_oe (dev_data_oe),
        .dev_data    (dev_data),
        .dev_strobe  (dev_strobe)
    );

    // Each loaded word is one pop.
    always_comb src_pop = load_word;

    // Checker counter: edges seen with the acknowledge low during a request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ack_age <= '0;
        else if (dev_req && !host_ack_n && (ack_age != '1)) ack_age <= ack_age + 1'b1;
    end

    // R3 R4: drive-on never comes before the envelope minimum after acknowledge.
    assert_env_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_data_oe) |-> (ack_age > {1'b0, tim.env_min}));

    // R5: drive-on follows an edge that saw the host acknowledged, not stopped and ready.
    assert_host_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_data_oe) |-> (!$past(host_stop) && !$past(host_ready_n) && !$past(host_ack_n)));

    // R8: a pop only takes a word that is there.
    assert_pop_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> src_valid);

    // R9: an empty source leaves the data on the bus untouched.
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(src_valid)) |-> $stable(dev_data));
endmodule

// File: tb/udma_rd_init_test.sv
`timescale 1ns/1ps
module udma_rd_init_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        src_valid;
    logic [15:0] src_data;
    logic        src_pop;
    logic        host_ack_n = 1'b1;
    logic        host_stop = 1'b1;
    logic        host_ready_n = 1'b1;
    logic        dev_req;
    logic        dev_data_oe;
    logic [15:0] dev_data;
    logic        dev_strobe;

    int checks = 0;
    int failures = 0;
    int wd_cnt = 0;

    // Source model.
    logic [15:0] fifo_mem [8];
    int          fifo_len = 0;
    int          rd_idx = 0;
    logic        fifo_clear = 1'b0;

    localparam int ENV_MIN = 5;  // R11: ceil(20 ns / 4 ns)
    localparam int NWORDS  = 5;
    localparam int ROWS    = 8;
    // mode, mode after start, setup, hold, lead, env max, first-strobe max
    localparam int VEC [ROWS][7] = '{
        '{0, 0, 18, 2, 18, 17, 57},
        '{1, 1, 12, 2, 12, 17, 50},
        '{2, 2,  8, 2,  8, 17, 42},
        '{3, 3,  5, 2,  5, 13, 32},
        '{4, 4,  2, 2,  2, 13, 30},
        '{5, 5,  2, 2,  9, 12, 22},
        '{7, 7,  2, 2,  9, 12, 22},   // R10: code 7 uses mode 5
        '{0, 5, 18, 2, 18, 17, 57}    // R10: mode change after start ignored
    };

    always #2 clk = ~clk;

    udma_rd_init uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
        .host_ack_n(host_ack_n), .host_stop(host_stop), .host_ready_n(host_ready_n),
        .dev_req(dev_req), .dev_data_oe(dev_data_oe), .dev_data(dev_data),
        .dev_strobe(dev_strobe)
    );

    assign src_valid = (rd_idx < fifo_len);
    assign src_data  = fifo_mem[rd_idx[2:0]];

    always @(posedge clk) begin
        if (fifo_clear)   rd_idx <= 0;
        else if (src_pop) rd_idx <= rd_idx + 1;
    end

    task automatic print_summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd_cnt, 150000);
            print_summary();
            $finish;
        end
    end

    function automatic logic [15:0] word_of(int r, int k);
        return 16'(((r + 1) * 4951) ^ (k * 9320) ^ 3855);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count negedges until the strobe (or data) moves; flag any move of the other.
    task automatic wait_change(input bit on_strobe, output int n, output bit other_moved);
        logic        s0;
        logic [15:0] d0;
        bit          done;
        s0 = dev_strobe; d0 = dev_data; n = 0; other_moved = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            n = n + 1;
            if (on_strobe) begin
                if (dev_data != d0) other_moved = 1;
                if (dev_strobe != s0) done = 1;
            end else begin
                if (dev_strobe != s0) other_moved = 1;
                if (dev_data != d0) done = 1;
            end
            if (n >= 400) done = 1;
        end
    endtask

    task automatic start_reset(input int r, input int len, input logic [2:0] m);
        rst_n = 1'b0;
        host_ack_n = 1'b1; host_stop = 1'b1; host_ready_n = 1'b1;
        mode_sel = m;
        for (int k = 0; k < 8; k++) fifo_mem[k] = word_of(r, k);
        fifo_len = len;
        fifo_clear = 1'b1;
        repeat (2) @(negedge clk);
        fifo_clear = 1'b0;
    endtask

    task automatic run_row(input int r);
        int n;
        bit moved;
        logic [15:0] d_hold;
        logic        s_hold;
        start_reset(r, NWORDS, 3'(VEC[r][0]));
        rst_n = 1'b1;
        @(negedge clk);
        check(dev_req == 1'b1, "R2", "request one edge after valid", dev_req, 1);
        mode_sel = 3'(VEC[r][1]);
        repeat (3) @(negedge clk);
        host_ack_n = 1'b0; host_stop = 1'b0; host_ready_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!dev_data_oe && n < 100);
        check(n == ENV_MIN + 2, "R4 R11", "acknowledge to drive-on", n, ENV_MIN + 2);
        check(n - 1 <= VEC[r][5], "R4", "drive-on within envelope max", n - 1, VEC[r][5]);
        check(dev_data == word_of(r, 0), "R6 R8", "first word at drive-on",
              dev_data, word_of(r, 0));
        check(dev_strobe == 1'b1, "R6", "strobe level at drive-on", dev_strobe, 1);
        wait_change(1'b1, n, moved);
        check(n == VEC[r][4], "R6 R10 R11", "lead to first strobe", n, VEC[r][4]);
        check(n <= VEC[r][6], "R6", "first strobe within max", n, VEC[r][6]);
        check(dev_strobe == 1'b0, "R6", "first transition falls", dev_strobe, 0);
        check(!moved, "R7", "data still before first strobe", moved, 0);
        for (int k = 1; k < NWORDS; k++) begin
            wait_change(1'b0, n, moved);
            check(n == VEC[r][3], "R7 R11", "hold after strobe edge", n, VEC[r][3]);
            check(dev_data == word_of(r, k), "R8", "word order", dev_data, word_of(r, k));
            check(!moved, "R7", "strobe still during hold", moved, 0);
            wait_change(1'b1, n, moved);
            check(n == VEC[r][2], "R7 R10 R11", "setup before strobe edge", n, VEC[r][2]);
            check(!moved, "R7", "data still during setup", moved, 0);
            check(dev_strobe == ((k % 2) == 1), "R8", "strobe alternates",
                  dev_strobe, (k % 2));
        end
        d_hold = dev_data; s_hold = dev_strobe; moved = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (dev_data != d_hold || dev_strobe != s_hold) moved = 1;
        end
        check(!moved, "R9", "bus frozen with empty source", moved, 0);
        check(rd_idx == NWORDS, "R8", "one pop per word", rd_idx, NWORDS);
    endtask

    initial begin
        int n;
        bit seen;
        for (int r = 0; r < ROWS; r++) run_row(r);

        // R1: reset state.
        start_reset(20, 3, 3'd3);
        check(dev_req == 1'b0, "R1", "request at reset", dev_req, 0);
        check(dev_data_oe == 1'b0, "R1", "drive at reset", dev_data_oe, 0);
        check(dev_strobe == 1'b1 && dev_data == 16'd0, "R1", "strobe and data at reset",
              {dev_strobe, dev_data}, 32'h10000);
        check(src_pop == 1'b0, "R1", "no pop at reset", src_pop, 0);

        // R3: host ready lines before acknowledge do nothing.
        host_stop = 1'b0; host_ready_n = 1'b0;
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dev_data_oe || src_pop) seen = 1;
        end
        check(!seen, "R3", "no drive before acknowledge", seen, 0);
        check(dev_req == 1'b1, "R3", "request held while waiting", dev_req, 1);

        // R5: unlimited wait for stop low and ready low together.
        host_ack_n = 1'b0; host_ready_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dev_data_oe) seen = 1;
        end
        check(!seen, "R5", "no drive while host not ready", seen, 0);
        host_stop = 1'b1; host_ready_n = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dev_data_oe) seen = 1;
        end
        check(!seen, "R5", "no drive while host stopped", seen, 0);
        host_stop = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!dev_data_oe && n < 50);
        check(n == 1, "R5", "drive on first ready edge", n, 1);
        check(dev_data == word_of(20, 0), "R5 R8", "word at late drive",
              dev_data, word_of(20, 0));

        // R1: reset in mid-burst returns to rest.
        rst_n = 1'b0;
        @(negedge clk);
        check(!dev_data_oe && !dev_req && dev_strobe, "R1", "mid-burst reset",
              {dev_data_oe, dev_req, dev_strobe}, 1);

        print_summary();
        $finish;
    end
endmodule